// File: doc/BRIEF.md
# Dual-Bank Aperture Address Translator

This block turns a 17-bit host aperture offset into a linear video-memory byte address. Two programmable bank registers supply the base. When dual banking is enabled, the upper 32 KB half of a 64 KB window takes its base from the second bank. A mode bit chooses whether one bank step is 4 KB or 16 KB. The sum of the masked offset and the bank base wraps within a 2 MB memory.

In planar (non-packed) modes the block also decodes the legacy window selector. That selector picks the whole 128 KB aperture, its low 64 KB, or one of its two upper 32 KB halves. A write outside the chosen window is dropped. A read outside it still completes, and the consumer returns 0xFF for it. When the extension registers are locked, banking is bypassed and the request is flagged for the standard addressing path.

Every result is registered, one clock after the request. A consumer takes `out_mem_en` as the strobe for a real memory access.

Top module: `aperture_xlate`

## Requirements
- R1: When `ext_locked` is 1, a valid request gives `out_legacy`=1, `out_mem_en`=0 and `out_fill`=0, and `out_addr` is the raw offset zero-extended.
- R2: Bank 1 is used only when `mode_ext` bit 0 is 1 and the offset lies in 0x08000–0x0FFFF. Every other request uses bank 0.
- R3: The bank base is bank×0x4000 when `mode_ext` bit 5 is 1, and bank×0x1000 when it is 0.
- R4: With `packed_mode`=1 the offset is masked to 0x7FFF when `mode_ext` bit 0 is 1 and to 0xFFFF otherwise. The window selector is ignored, every access is enabled, and offset plus base wraps modulo 0x200000.
- R5: In planar mode with `map_sel`=0 the full 17-bit offset is added to the base, and every access is enabled.
- R6: In planar mode with `map_sel`=1 the offset is masked as in R4. A write with offset bit 16 set is dropped (`out_mem_en`=0).
- R7: In planar mode with `map_sel`=2 the window is offsets 0x10000–0x17FFF, and with `map_sel`=3 it is 0x18000–0x1FFFF. The window-relative offset (low 15 bits) is used, and writes outside the window are dropped.
- R8: A planar read outside its window still completes: `out_valid`=1, `out_fill`=1 (the consumer returns 0xFF), `out_mem_en`=0 and `out_addr`=0. A dropped write has `out_fill`=0 and `out_addr`=0.
- R9: Outputs appear exactly one clock after the request. A cycle with `req_valid`=0 gives `out_valid`, `out_mem_en`, `out_fill`, `out_legacy` all 0 and `out_addr`=0 on the next cycle.
- R10: While reset is held, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A host access is presented this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_offset | input | 17 | Host aperture offset |
| ext_locked | input | 1 | Extension registers locked; bypass banking |
| mode_ext | input | 8 | Mode-extension byte (bit 0 dual bank, bit 5 coarse granularity) |
| bank0 | input | 8 | Bank 0 register |
| bank1 | input | 8 | Bank 1 register |
| map_sel | input | 2 | Legacy window selector |
| packed_mode | input | 1 | Packed-pixel mode active |
| out_valid | output | 1 | Result of the previous cycle's request |
| out_mem_en | output | 1 | Perform the memory access at out_addr |
| out_fill | output | 1 | Out-of-window read; return 0xFF |
| out_legacy | output | 1 | Route to standard addressing (locked) |
| out_addr | output | 21 | Linear video-memory address |

## Verification
The assertions assume that all request inputs are stable and known from just after one falling edge through the next rising edge. They also assume that `req_valid` fully qualifies the other request fields. The stimulus meets this by changing every input only at falling edges and by returning `req_valid` to 0 between the vector table and the directed tests. Reset is applied only while no request is driven, so the reset synchronizer's release never coincides with a new request.

// File: rtl/aperture_pkg.sv
package aperture_pkg;

  // Window selector encodings used in planar modes.
  typedef enum logic [1:0] {
    WIN_ALL    = 2'd0,
    WIN_LOW64  = 2'd1,
    WIN_MID32  = 2'd2,
    WIN_HIGH32 = 2'd3
  } win_sel_e;

  // Mode-extension bit positions the decode depends on.
  localparam int EXT_DUAL_BIT = 0;
  localparam int EXT_GRAN_BIT = 5;

endpackage

// File: rtl/aperture_bank_sel.sv
module aperture_bank_sel #(
  parameter int OFF_W        = 17,
  parameter int BANK_W       = 8,
  parameter int ADDR_W       = 21,
  parameter int FINE_SHIFT   = 12,
  parameter int COARSE_SHIFT = 14
) (
  input  logic [OFF_W-1:0]  offset,
  input  logic              dual_en,
  input  logic              coarse,
  input  logic [BANK_W-1:0] bank_lo,
  input  logic [BANK_W-1:0] bank_hi,
  output logic              use_hi,
  output logic [ADDR_W-1:0] base
);

  localparam int WIDE_W = ADDR_W + BANK_W;
  localparam int TOP_B  = OFF_W - 1;
  localparam int HALF_B = OFF_W - 2;

  logic [BANK_W-1:0] chosen;
  logic [WIDE_W-1:0] wide;

  // Upper 32 KB of the low 64 KB region goes to the second bank.
  always_comb begin
    use_hi = dual_en && !offset[TOP_B] && offset[HALF_B];
    chosen = use_hi ? bank_hi : bank_lo;
    if (coarse) wide = WIDE_W'(chosen) << COARSE_SHIFT;
    else        wide = WIDE_W'(chosen) << FINE_SHIFT;
    base = wide[ADDR_W-1:0];
  end

endmodule

// File: rtl/aperture_window.sv
module aperture_window
  import aperture_pkg::*;
#(
  parameter int OFF_W = 17
) (
  input  logic [OFF_W-1:0] offset,
  input  logic             packed_px,
  input  logic             dual_en,
  input  logic [1:0]       sel,
  output logic [OFF_W-1:0] eff_off,
  output logic             in_window
);

  localparam int            TOP_B     = OFF_W - 1;
  localparam int            HALF_B    = OFF_W - 2;
  localparam logic [OFF_W-1:0] HALF_MASK = (OFF_W'(1) << HALF_B) - OFF_W'(1);
  localparam logic [OFF_W-1:0] FULL_MASK = (OFF_W'(1) << TOP_B) - OFF_W'(1);
  localparam logic [OFF_W-1:0] MID_BASE  = OFF_W'(1) << TOP_B;
  localparam logic [OFF_W-1:0] HIGH_BASE = (OFF_W'(3) << HALF_B);

  logic [OFF_W-1:0] bank_mask;

  always_comb begin
    bank_mask = dual_en ? HALF_MASK : FULL_MASK;
    eff_off   = offset;
    in_window = 1'b1;
    if (packed_px) begin
      eff_off = offset & bank_mask;
    end else begin
      unique case (win_sel_e'(sel))
        WIN_ALL: begin
          eff_off = offset;
        end
        WIN_LOW64: begin
          eff_off   = offset & bank_mask;
          in_window = !offset[TOP_B];
        end
        WIN_MID32: begin
          eff_off   = (offset - MID_BASE) & HALF_MASK;
          in_window = (offset[TOP_B:HALF_B] == 2'b10);
        end
        WIN_HIGH32: begin
          eff_off   = (offset - HIGH_BASE) & HALF_MASK;
          in_window = (offset[TOP_B:HALF_B] == 2'b11);
        end
        default: begin
          eff_off = offset;
        end
      endcase
    end
  end

endmodule

// File: rtl/aperture_xlate.sv
module aperture_xlate
  import aperture_pkg::*;
#(
  parameter int OFF_W  = 17,
  parameter int BANK_W = 8,
  parameter int ADDR_W = 21,
  parameter int EXT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic              ext_locked,
  input  logic [EXT_W-1:0]  mode_ext,
  input  logic [BANK_W-1:0] bank0,
  input  logic [BANK_W-1:0] bank1,
  input  logic [1:0]        map_sel,
  input  logic              packed_mode,
  output logic              out_valid,
  output logic              out_mem_en,
  output logic              out_fill,
  output logic              out_legacy,
  output logic [ADDR_W-1:0] out_addr
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic dual_en, coarse;
  assign dual_en = mode_ext[EXT_DUAL_BIT];
  assign coarse  = mode_ext[EXT_GRAN_BIT];

  logic unused_ext_bits;
  assign unused_ext_bits = ^{mode_ext[EXT_W-1:EXT_GRAN_BIT+1],
                             mode_ext[EXT_GRAN_BIT-1:EXT_DUAL_BIT+1]};

  logic              use_hi;
  logic [ADDR_W-1:0] base;
  logic [OFF_W-1:0]  eff_off;
  logic              in_window;

  aperture_bank_sel #(
    .OFF_W (OFF_W),
    .BANK_W(BANK_W),
    .ADDR_W(ADDR_W)
  ) u_bank (
    .offset (req_offset),
    .dual_en(dual_en),
    .coarse (coarse),
    .bank_lo(bank0),
    .bank_hi(bank1),
    .use_hi (use_hi),
    .base   (base)
  );

  aperture_window #(
    .OFF_W(OFF_W)
  ) u_win (
    .offset   (req_offset),
    .packed_px(packed_mode),
    .dual_en  (dual_en),
    .sel      (map_sel),
    .eff_off  (eff_off),
    .in_window(in_window)
  );

  logic unused_sel;
  assign unused_sel = use_hi;

  // Next-state logic.
  logic              nx_valid, nx_en, nx_fill, nx_legacy;
  logic [ADDR_W-1:0] nx_addr, sum;

  always_comb begin
    sum       = ADDR_W'(eff_off) + base;
    nx_valid  = req_valid;
    nx_en     = 1'b0;
    nx_fill   = 1'b0;
    nx_legacy = 1'b0;
    nx_addr   = '0;
    if (req_valid) begin
      if (ext_locked) begin
        nx_legacy = 1'b1;
        nx_addr   = ADDR_W'(req_offset);
      end else if (in_window) begin
        nx_en   = 1'b1;
        nx_addr = sum;
      end else if (!req_write) begin
        nx_fill = 1'b1;
      end
    end
  end

  // Registers, loaded only when something is or was in flight.
  logic load;
  assign load = req_valid | out_valid;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid  <= 1'b0;
      out_mem_en <= 1'b0;
      out_fill   <= 1'b0;
      out_legacy <= 1'b0;
      out_addr   <= '0;
    end else if (load) begin
      out_valid  <= nx_valid;
      out_mem_en <= nx_en;
      out_fill   <= nx_fill;
      out_legacy <= nx_legacy;
      out_addr   <= nx_addr;
    end
  end

  // Checks on the registered outputs.
  p_locked_no_access_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_legacy |-> (!out_mem_en && !out_fill));

  p_low64_write_drop_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_write && !ext_locked && !packed_mode && map_sel == 2'd1
     && req_offset[OFF_W-1]) |=> !out_mem_en);

  p_mid32_write_drop_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_write && !ext_locked && !packed_mode && map_sel == 2'd2
     && req_offset[OFF_W-1:OFF_W-2] != 2'b10) |=> !out_mem_en);

  p_fill_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_fill |-> (!out_mem_en && out_valid && out_addr == '0));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> (!out_valid && !out_mem_en && !out_fill && !out_legacy));

  p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> out_valid);

endmodule

// File: tb/tb_aperture_xlate.sv
module tb_aperture_xlate;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, ext_locked, packed_mode;
  logic [16:0] req_offset;
  logic [7:0]  mode_ext, bank0, bank1;
  logic [1:0]  map_sel;
  logic        out_valid, out_mem_en, out_fill, out_legacy;
  logic [20:0] out_addr;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  aperture_xlate dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_offset(req_offset), .ext_locked(ext_locked), .mode_ext(mode_ext),
    .bank0(bank0), .bank1(bank1), .map_sel(map_sel), .packed_mode(packed_mode),
    .out_valid(out_valid), .out_mem_en(out_mem_en), .out_fill(out_fill),
    .out_legacy(out_legacy), .out_addr(out_addr)
  );

  typedef struct packed {
    logic        lk;
    logic        wr;
    logic [7:0]  mx;
    logic [7:0]  b0;
    logic [7:0]  b1;
    logic [1:0]  ms;
    logic        pk;
    logic [16:0] off;
    logic        en;
    logic        fill;
    logic        leg;
    logic [20:0] addr;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    // R1 locked bypass
    '{1'b1,1'b0,8'h00,8'h05,8'h00,2'd0,1'b1,17'h01234, 1'b0,1'b0,1'b1,21'h001234},
    // R4 packed, single bank, 4 KB steps, mask 0xFFFF
    '{1'b0,1'b1,8'h00,8'h03,8'h00,2'd0,1'b1,17'h1ABCD, 1'b1,1'b0,1'b0,21'h00DBCD},
    // R3 16 KB steps
    '{1'b0,1'b0,8'h20,8'h10,8'h00,2'd0,1'b1,17'h00100, 1'b1,1'b0,1'b0,21'h040100},
    // R2 dual bank, upper half uses bank 1
    '{1'b0,1'b0,8'h21,8'h01,8'h02,2'd0,1'b1,17'h09004, 1'b1,1'b0,1'b0,21'h009004},
    // R2 dual bank, lower half uses bank 0
    '{1'b0,1'b0,8'h21,8'h01,8'h02,2'd0,1'b1,17'h00010, 1'b1,1'b0,1'b0,21'h004010},
    // R4 wrap at 2 MB
    '{1'b0,1'b1,8'h20,8'h80,8'h00,2'd0,1'b1,17'h00020, 1'b1,1'b0,1'b0,21'h000020},
    '{1'b0,1'b0,8'h20,8'h7F,8'h00,2'd0,1'b1,17'h0FFFF, 1'b1,1'b0,1'b0,21'h00BFFF},
    // R5 planar full aperture
    '{1'b0,1'b1,8'h00,8'h00,8'h00,2'd0,1'b0,17'h1F000, 1'b1,1'b0,1'b0,21'h01F000},
    // R6 low64 write above 64 KB dropped
    '{1'b0,1'b1,8'h00,8'h01,8'h00,2'd1,1'b0,17'h12345, 1'b0,1'b0,1'b0,21'h000000},
    // R8 low64 read outside window fills
    '{1'b0,1'b0,8'h00,8'h01,8'h00,2'd1,1'b0,17'h12345, 1'b0,1'b1,1'b0,21'h000000},
    // R6 low64 in window, dual bank picks bank 1
    '{1'b0,1'b1,8'h01,8'h02,8'h04,2'd1,1'b0,17'h08010, 1'b1,1'b0,1'b0,21'h004010},
    // R6 low64 in window, dual off, bank 0 even in upper half
    '{1'b0,1'b1,8'h00,8'h01,8'h04,2'd1,1'b0,17'h0F000, 1'b1,1'b0,1'b0,21'h010000},
    // R7 mid32 in window
    '{1'b0,1'b1,8'h00,8'h01,8'h00,2'd2,1'b0,17'h10020, 1'b1,1'b0,1'b0,21'h001020},
    // R7 mid32 write outside dropped
    '{1'b0,1'b1,8'h00,8'h01,8'h00,2'd2,1'b0,17'h18020, 1'b0,1'b0,1'b0,21'h000000},
    // R7 high32 in window
    '{1'b0,1'b1,8'h00,8'h01,8'h00,2'd3,1'b0,17'h18020, 1'b1,1'b0,1'b0,21'h001020},
    // R8 high32 read outside fills
    '{1'b0,1'b0,8'h00,8'h01,8'h00,2'd3,1'b0,17'h10020, 1'b0,1'b1,1'b0,21'h000000},
    // R7 mid32 read at top of window
    '{1'b0,1'b0,8'h00,8'h00,8'h00,2'd2,1'b0,17'h17FFF, 1'b1,1'b0,1'b0,21'h007FFF},
    // R4 packed ignores the window selector
    '{1'b0,1'b1,8'h00,8'h00,8'h00,2'd2,1'b1,17'h00040, 1'b1,1'b0,1'b0,21'h000040}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_valid   = 1'b1;
    req_write   = v.wr;
    ext_locked  = v.lk;
    mode_ext    = v.mx;
    bank0       = v.b0;
    bank1       = v.b1;
    map_sel     = v.ms;
    packed_mode = v.pk;
    req_offset  = v.off;
  endtask

  task automatic idle();
    req_valid = 1'b0; req_write = 1'b0; ext_locked = 1'b0; mode_ext = '0;
    bank0 = '0; bank1 = '0; map_sel = '0; packed_mode = 1'b0; req_offset = '0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10 outputs cleared under reset
    chk("R10 valid", {31'b0, out_valid}, 32'd0);
    chk("R10 en",    {31'b0, out_mem_en}, 32'd0);
    chk("R10 fill",  {31'b0, out_fill}, 32'd0);
    chk("R10 legacy",{31'b0, out_legacy}, 32'd0);
    chk("R10 addr",  {11'b0, out_addr}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      chk($sformatf("R9 valid v%0d", i), {31'b0, out_valid}, 32'd1);
      chk($sformatf("en v%0d", i),   {31'b0, out_mem_en}, {31'b0, TBL[i].en});
      chk($sformatf("R8 fill v%0d", i), {31'b0, out_fill}, {31'b0, TBL[i].fill});
      chk($sformatf("R1 legacy v%0d", i), {31'b0, out_legacy}, {31'b0, TBL[i].leg});
      chk($sformatf("addr v%0d", i), {11'b0, out_addr}, {11'b0, TBL[i].addr});
    end

    // R9 idle cycle clears outputs
    idle();
    @(negedge clk);
    chk("R9 idle valid", {31'b0, out_valid}, 32'd0);
    chk("R9 idle en",    {31'b0, out_mem_en}, 32'd0);
    chk("R9 idle addr",  {11'b0, out_addr}, 32'd0);

    // R9 latency: nothing before the edge, result after it
    drive(TBL[2]);
    #4;
    chk("R9 before edge", {31'b0, out_valid}, 32'd0);
    @(negedge clk);
    chk("R9 after edge", {11'b0, out_addr}, 32'h040100);
    idle();
    @(negedge clk);

    // R10 asynchronous reset mid-stream
    drive(TBL[1]);
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    #1;
    chk("R10 async clear", {31'b0, out_mem_en}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule